// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block carries out one atomic memory instruction at a time for a 64-bit core: the nine read-modify-write operations (swap, add, xor, and, or, and signed and unsigned min and max), load-reserved and store-conditional. Each can work on a 32-bit or a 64-bit quantity. The core presents one request with the instruction's funct5, funct3 and rs2 register field, the effective address and the rs2 operand. The unit then runs the memory traffic itself and returns the value destined for rd with a one-cycle done pulse.

The memory side is a plain synchronous port. A read request is held, with its address, until the memory answers with a valid strobe, which may come after any number of cycles. A write is a single-cycle strobe that the memory always takes. All data is right-justified: a 32-bit access uses bits 31:0. One local reservation register gives load-reserved and store-conditional their pairing. Ordering bits, coherence and arbitration between several cores belong to other blocks.

Top module: `amo_rmw_unit`

## Requirements
- R1: The funct5 value selects the operation. 00001 is swap (new value = rs2), 00000 is add, 00100 is xor, 01100 is and and 01000 is or. 10000 and 10100 are signed min and max, and 11000 and 11100 are unsigned min and max. The new value is written back to the same address.
- R2: For a read-modify-write operation, rsp_rd_val is the old memory value. A 32-bit operation sign-extends bit 31 of that value and ignores mem_rd_data[63:32].
- R3: A 32-bit operation computes on the low 32 bits only, with 32-bit signed or unsigned comparison for min and max. It writes with mem_dword=0 and mem_wr_data[63:32]=0. A 64-bit operation writes with mem_dword=1.
- R4: funct3 010 selects 32-bit and 011 selects 64-bit. Any other funct3, or any funct5 not named in R1, R5 or R6, sets rsp_illegal. Such a request makes no memory access, leaves the reservation as it was and returns rd 0.
- R5: funct5 00010 with an rs2 field of 0 is load-reserved. It reads memory, returns the value extended as in R2 and records a valid reservation on the address. With a non-zero rs2 field, the same funct5 is illegal as in R4.
- R6: funct5 00011 is store-conditional. When the reservation is valid and its address equals the request address, the unit writes rs2 (low 32 bits only for 32-bit) and returns 0. Otherwise it returns 1 and issues no read and no write.
- R7: Every store-conditional that is neither illegal nor misaligned clears the reservation, whether it succeeds or fails.
- R8: An address not aligned to the access size (4 or 8 bytes) sets rsp_misaligned. Such a request makes no memory access, returns rd 0 and leaves the reservation unchanged. Every memory strobe carries an aligned address.
- R9: req_ready is high only in the idle state, so one request is in flight at a time. The operation passes through read, compute, write and done states as it needs them. rsp_done is high for exactly one cycle per request, after which req_ready is high again. A read and a write are never requested in the same cycle.
- R10: mem_rd_req stays high with a stable mem_addr until mem_rd_valid. Any read latency gives the same results.
- R11: After reset, req_ready is 1 and mem_rd_req, mem_wr_req and rsp_done are 0. The reservation is invalid, so a first store-conditional fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request taken this cycle |
| req_funct5 | input | 5 | Operation field of the instruction |
| req_funct3 | input | 3 | Size field (010 = 32-bit, 011 = 64-bit) |
| req_rs2_field | input | 5 | rs2 register index field of the instruction |
| req_addr | input | ADDR_W | Byte address |
| req_rs2_val | input | DATA_W | rs2 operand value |
| mem_rd_req | output | 1 | Read request, held until answered |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | DATA_W | Read data, right-justified |
| mem_wr_req | output | 1 | Single-cycle write strobe |
| mem_addr | output | ADDR_W | Address of the read or write |
| mem_dword | output | 1 | 1 = 64-bit access, 0 = 32-bit access |
| mem_wr_data | output | DATA_W | Write data, right-justified |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rd_val | output | DATA_W | Value for rd, valid with rsp_done |
| rsp_illegal | output | 1 | Illegal encoding, valid with rsp_done |
| rsp_misaligned | output | 1 | Misaligned address, valid with rsp_done |

## Verification
The bench builds the unit with ADDR_W=16, DATA_W=64 and exact-address reservation matching (RESV_MATCH_LSB=0). The 16-bit address lets a 16-doubleword memory model reach every word. Because both halves of each word are in play, a 32-bit result must not disturb its neighbour half. The model answers reads after a random 0 to 3 cycles and fills the unused upper half of 32-bit reads with noise. That exercises held read requests and the narrow sign-extension. Reservation mismatch and misaligned offsets fall within the same 128-byte window, so directed pairings and random streams mix successful and failing store-conditionals.

// File: rtl/amo_pkg.sv
package amo_pkg;
   localparam logic [2:0] F3_WORD  = 3'b010;
   localparam logic [2:0] F3_DWORD = 3'b011;

   typedef enum logic [3:0] {
      OP_SWAP, OP_ADD, OP_XOR, OP_AND, OP_OR,
      OP_MIN, OP_MAX, OP_MINU, OP_MAXU,
      OP_LR, OP_SC, OP_BAD
   } amo_op_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_READ, ST_CALC, ST_WRITE, ST_DONE
   } amo_state_e;

   function automatic amo_op_e map_funct5(input logic [4:0] f5, input logic [4:0] rs2f);
      case (f5)
         5'b00001: return OP_SWAP;
         5'b00000: return OP_ADD;
         5'b00100: return OP_XOR;
         5'b01100: return OP_AND;
         5'b01000: return OP_OR;
         5'b10000: return OP_MIN;
         5'b10100: return OP_MAX;
         5'b11000: return OP_MINU;
         5'b11100: return OP_MAXU;
         5'b00010: return (rs2f == 5'd0) ? OP_LR : OP_BAD;
         5'b00011: return OP_SC;
         default:  return OP_BAD;
      endcase
   endfunction
endpackage

// File: rtl/amo_decode.sv
module amo_decode
   import amo_pkg::*;
(
   input  logic [4:0] funct5,
   input  logic [2:0] funct3,
   input  logic [4:0] rs2_field,
   input  logic [2:0] addr_lsb,
   output amo_op_e    op,
   output logic       dword,
   output logic       illegal,
   output logic       misaligned
);
   logic size_ok;

   always_comb begin
      op         = map_funct5(funct5, rs2_field);
      dword      = (funct3 == F3_DWORD);
      size_ok    = (funct3 == F3_WORD) || (funct3 == F3_DWORD);
      illegal    = (op == OP_BAD) || !size_ok;
      misaligned = !illegal && (dword ? (addr_lsb != 3'd0) : (addr_lsb[1:0] != 2'd0));
   end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
   import amo_pkg::*;
#(
   parameter int DATA_W = 64
)(
   input  amo_op_e            op,
   input  logic               dword,
   input  logic [DATA_W-1:0]  mem_val,
   input  logic [DATA_W-1:0]  rs2_val,
   output logic [DATA_W-1:0]  new_val
);
   localparam int HALF_W = DATA_W / 2;

   logic              sgn;
   logic [DATA_W-1:0] a, b, res;
   logic              lt_s, lt_u;

   always_comb begin
      sgn = (op == OP_MIN) || (op == OP_MAX);
      if (dword) begin
         a = mem_val;
         b = rs2_val;
      end else if (sgn) begin
         a = {{HALF_W{mem_val[HALF_W-1]}}, mem_val[HALF_W-1:0]};
         b = {{HALF_W{rs2_val[HALF_W-1]}}, rs2_val[HALF_W-1:0]};
      end else begin
         a = {{HALF_W{1'b0}}, mem_val[HALF_W-1:0]};
         b = {{HALF_W{1'b0}}, rs2_val[HALF_W-1:0]};
      end
      lt_s = $signed(a) < $signed(b);
      lt_u = a < b;
      case (op)
         OP_SWAP, OP_SC: res = b;
         OP_ADD:         res = a + b;
         OP_XOR:         res = a ^ b;
         OP_AND:         res = a & b;
         OP_OR:          res = a | b;
         OP_MIN:         res = lt_s ? a : b;
         OP_MAX:         res = lt_s ? b : a;
         OP_MINU:        res = lt_u ? a : b;
         OP_MAXU:        res = lt_u ? b : a;
         default:        res = a;
      endcase
      new_val = dword ? res : {{HALF_W{1'b0}}, res[HALF_W-1:0]};
   end
endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
   parameter int ADDR_W    = 32,
   parameter int MATCH_LSB = 0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set,
   input  logic              clear,
   input  logic [ADDR_W-1:0] set_addr,
   input  logic [ADDR_W-1:0] check_addr,
   output logic              hit
);
   logic              valid_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         addr_q  <= '0;
      end else if (set) begin
         valid_q <= 1'b1;
         addr_q  <= set_addr;
      end else if (clear) begin
         valid_q <= 1'b0;
      end
   end

   generate
      if (MATCH_LSB == 0) begin : g_exact
         assign hit = valid_q && (addr_q == check_addr);
      end else begin : g_granule
         assign hit = valid_q && (addr_q[ADDR_W-1:MATCH_LSB] == check_addr[ADDR_W-1:MATCH_LSB]);
      end
   endgenerate
endmodule

// File: rtl/amo_rmw_unit.sv
module amo_rmw_unit
   import amo_pkg::*;
#(
   parameter int ADDR_W         = 32,
   parameter int DATA_W         = 64,
   parameter int RESV_MATCH_LSB = 0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [4:0]        req_funct5,
   input  logic [2:0]        req_funct3,
   input  logic [4:0]        req_rs2_field,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_rs2_val,
   output logic              mem_rd_req,
   input  logic              mem_rd_valid,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              mem_wr_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_dword,
   output logic [DATA_W-1:0] mem_wr_data,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rd_val,
   output logic              rsp_illegal,
   output logic              rsp_misaligned
);
   localparam int HALF_W = DATA_W / 2;

   initial begin
      assert (DATA_W == 64) else $error("amo_rmw_unit: DATA_W must be 64");
      assert (ADDR_W >= 3) else $error("amo_rmw_unit: ADDR_W must be at least 3");
      assert (RESV_MATCH_LSB >= 0 && RESV_MATCH_LSB < ADDR_W)
         else $error("amo_rmw_unit: RESV_MATCH_LSB out of range");
   end

   function automatic logic [DATA_W-1:0] ext_load(input logic [DATA_W-1:0] v, input logic dw);
      return dw ? v : {{HALF_W{v[HALF_W-1]}}, v[HALF_W-1:0]};
   endfunction

   amo_state_e        state;
   amo_op_e           op_q, dec_op;
   logic              dword_q, dec_dword, dec_ill, dec_mis;
   logic              ill_q, mis_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] rs2_q, mem_q, rd_q, wdata_q, alu_new;
   logic              resv_hit, resv_set, resv_clear, take;

   amo_decode u_decode (
      .funct5     (req_funct5),
      .funct3     (req_funct3),
      .rs2_field  (req_rs2_field),
      .addr_lsb   (req_addr[2:0]),
      .op         (dec_op),
      .dword      (dec_dword),
      .illegal    (dec_ill),
      .misaligned (dec_mis)
   );

   amo_alu #(.DATA_W(DATA_W)) u_alu (
      .op      (op_q),
      .dword   (dword_q),
      .mem_val (mem_q),
      .rs2_val (rs2_q),
      .new_val (alu_new)
   );

   assign take       = (state == ST_IDLE) && req_valid;
   assign resv_set   = (state == ST_READ) && mem_rd_valid && (op_q == OP_LR);
   assign resv_clear = take && !dec_ill && !dec_mis && (dec_op == OP_SC);

   amo_resv #(.ADDR_W(ADDR_W), .MATCH_LSB(RESV_MATCH_LSB)) u_resv (
      .clk        (clk),
      .rst_n      (rst_n),
      .set        (resv_set),
      .clear      (resv_clear),
      .set_addr   (addr_q),
      .check_addr (req_addr),
      .hit        (resv_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         op_q    <= OP_BAD;
         dword_q <= 1'b0;
         ill_q   <= 1'b0;
         mis_q   <= 1'b0;
         addr_q  <= '0;
         rs2_q   <= '0;
         mem_q   <= '0;
         rd_q    <= '0;
         wdata_q <= '0;
      end else begin
         case (state)
            ST_IDLE: if (req_valid) begin
               op_q    <= dec_op;
               dword_q <= dec_dword;
               addr_q  <= req_addr;
               rs2_q   <= req_rs2_val;
               rd_q    <= '0;
               ill_q   <= dec_ill;
               mis_q   <= dec_mis;
               if (dec_ill || dec_mis) begin
                  state <= ST_DONE;
               end else if (dec_op == OP_SC) begin
                  rd_q  <= resv_hit ? '0 : DATA_W'(1);
                  state <= resv_hit ? ST_CALC : ST_DONE;
               end else begin
                  state <= ST_READ;
               end
            end
            ST_READ: if (mem_rd_valid) begin
               mem_q <= mem_rd_data;
               if (op_q == OP_LR) begin
                  rd_q  <= ext_load(mem_rd_data, dword_q);
                  state <= ST_DONE;
               end else begin
                  state <= ST_CALC;
               end
            end
            ST_CALC: begin
               wdata_q <= alu_new;
               if (op_q != OP_SC) rd_q <= ext_load(mem_q, dword_q);
               state <= ST_WRITE;
            end
            ST_WRITE: state <= ST_DONE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready      = (state == ST_IDLE);
   assign mem_rd_req     = (state == ST_READ);
   assign mem_wr_req     = (state == ST_WRITE);
   assign mem_addr       = addr_q;
   assign mem_dword      = dword_q;
   assign mem_wr_data    = wdata_q;
   assign rsp_done       = (state == ST_DONE);
   assign rsp_rd_val     = rd_q;
   assign rsp_illegal    = ill_q;
   assign rsp_misaligned = mis_q;
endmodule

// File: rtl/amo_rmw_checker.sv
module amo_rmw_checker #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64
)(
   input logic                     clk,
   input logic                     rst_n,
   input logic                     req_valid,
   input logic                     req_ready,
   input logic                     mem_rd_req,
   input logic                     mem_rd_valid,
   input logic                     mem_wr_req,
   input logic [ADDR_W-1:0]        mem_addr,
   input logic                     mem_dword,
   input logic [DATA_W-1:DATA_W/2] mem_wr_hi,
   input logic                     rsp_done
);
   // R9: a taken request makes the unit busy on the next cycle
   assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R9: completion is a single pulse followed by idle
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> (!rsp_done && req_ready));

   // R9: read and write strobes never overlap
   assert_no_rd_wr_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_req && mem_wr_req));

   // R10: an unanswered read stays requested at the same address
   assert_read_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_addr)));

   // R8: memory is only ever touched at aligned addresses
   assert_aligned_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req || mem_wr_req) |-> (mem_dword ? (mem_addr[2:0] == 3'd0) : (mem_addr[1:0] == 2'd0)));

   // R3: a 32-bit write leaves the upper data half at zero
   assert_narrow_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_req && !mem_dword) |-> (mem_wr_hi == '0));

   // R6: a write is the last step before completion
   assert_write_then_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_req |=> rsp_done);
endmodule

bind amo_rmw_unit amo_rmw_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_amo_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .mem_rd_req   (mem_rd_req),
   .mem_rd_valid (mem_rd_valid),
   .mem_wr_req   (mem_wr_req),
   .mem_addr     (mem_addr),
   .mem_dword    (mem_dword),
   .mem_wr_hi    (mem_wr_data[DATA_W-1:DATA_W/2]),
   .rsp_done     (rsp_done)
);

// File: tb/test_amo_rmw_unit.sv
module test_amo_rmw_unit;
   localparam int AW = 16;
   localparam int DW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [4:0]    req_funct5 = '0;
   logic [2:0]    req_funct3 = '0;
   logic [4:0]    req_rs2_field = '0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_rs2_val = '0;
   logic          mem_rd_req, mem_wr_req, mem_dword;
   logic          mem_rd_valid;
   logic [DW-1:0] mem_rd_data;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wr_data;
   logic          rsp_done, rsp_illegal, rsp_misaligned;
   logic [DW-1:0] rsp_rd_val;

   always #5 clk = ~clk;

   amo_rmw_unit #(.ADDR_W(AW), .DATA_W(DW), .RESV_MATCH_LSB(0)) i_amo_rmw_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_funct5(req_funct5), .req_funct3(req_funct3), .req_rs2_field(req_rs2_field),
      .req_addr(req_addr), .req_rs2_val(req_rs2_val), .mem_rd_req(mem_rd_req),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req),
      .mem_addr(mem_addr), .mem_dword(mem_dword), .mem_wr_data(mem_wr_data),
      .rsp_done(rsp_done), .rsp_rd_val(rsp_rd_val), .rsp_illegal(rsp_illegal),
      .rsp_misaligned(rsp_misaligned)
   );

   int errors = 0;
   int checks = 0;

   function automatic logic [63:0] init_word(input int k);
      return (64'h9E37_79B9_7F4A_7C15 * 64'(k + 1)) ^ {32'(k) << 7, 32'hA5C3_0000 + 32'(k)};
   endfunction

   // Memory model; random read latency of 0..3 cycles exercises R10
   logic [63:0] mem [16];
   int          lat = 0;
   int          rd_cnt = 0;
   int          wr_cnt = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_rd_valid <= 1'b0;
         mem_rd_data  <= '0;
         lat          <= 0;
         for (int k = 0; k < 16; k++) mem[k] <= init_word(k);
      end else begin
         mem_rd_valid <= 1'b0;
         if (mem_rd_req && !mem_rd_valid) begin
            if (lat == 0) begin
               mem_rd_valid <= 1'b1;
               if (mem_dword) mem_rd_data <= mem[mem_addr[6:3]];
               else if (mem_addr[2]) mem_rd_data <= {$urandom, mem[mem_addr[6:3]][63:32]};
               else mem_rd_data <= {$urandom, mem[mem_addr[6:3]][31:0]};
               lat <= int'($urandom % 4);
            end else begin
               lat <= lat - 1;
            end
         end
         if (mem_rd_req && mem_rd_valid) rd_cnt <= rd_cnt + 1;
         if (mem_wr_req) begin
            wr_cnt <= wr_cnt + 1;
            if (mem_dword) mem[mem_addr[6:3]] <= mem_wr_data;
            else if (mem_addr[2]) mem[mem_addr[6:3]][63:32] <= mem_wr_data[31:0];
            else mem[mem_addr[6:3]][31:0] <= mem_wr_data[31:0];
         end
      end
   end

   // Bench-side expected state
   logic [63:0] shd [16];
   logic        res_v = 1'b0;
   logic [15:0] res_a = '0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [63:0] ref_new(input logic [4:0] f5, input bit dw,
                                           input logic [63:0] old, input logic [63:0] b);
      logic [31:0] o, c, r;
      if (dw) begin
         case (f5)
            5'b00000: return old + b;
            5'b00100: return old ^ b;
            5'b01100: return old & b;
            5'b01000: return old | b;
            5'b10000: return ($signed(old) < $signed(b)) ? old : b;
            5'b10100: return ($signed(old) > $signed(b)) ? old : b;
            5'b11000: return (old < b) ? old : b;
            5'b11100: return (old > b) ? old : b;
            default:  return b;
         endcase
      end
      o = old[31:0];
      c = b[31:0];
      case (f5)
         5'b00000: r = o + c;
         5'b00100: r = o ^ c;
         5'b01100: r = o & c;
         5'b01000: r = o | c;
         5'b10000: r = ($signed(o) < $signed(c)) ? o : c;
         5'b10100: r = ($signed(o) > $signed(c)) ? o : c;
         5'b11000: r = (o < c) ? o : c;
         5'b11100: r = (o > c) ? o : c;
         default:  r = c;
      endcase
      return {32'h0, r};
   endfunction

   function automatic bit is_rmw(input logic [4:0] f5);
      case (f5)
         5'b00001, 5'b00000, 5'b00100, 5'b01100, 5'b01000,
         5'b10000, 5'b10100, 5'b11000, 5'b11100: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic run_op(input logic [4:0] f5, input logic [2:0] f3, input logic [4:0] rs2f,
                         input logic [15:0] a, input logic [63:0] b, input string tag);
      bit          dw, ill, mis, known;
      logic [63:0] old, exp_rd, nv;
      int          exp_r, exp_w, r0, w0, n;
      bit          mem_ok;
      int          idx;
      dw    = (f3 == 3'b011);
      known = is_rmw(f5) || (f5 == 5'b00011) || (f5 == 5'b00010 && rs2f == 5'd0);
      ill   = !known || !(f3 == 3'b010 || f3 == 3'b011);
      mis   = !ill && (dw ? (a[2:0] != 3'd0) : (a[1:0] != 2'd0));
      idx   = int'(a[6:3]);
      exp_rd = '0; exp_r = 0; exp_w = 0;
      if (!ill && !mis) begin
         old = dw ? shd[idx] : (a[2] ? {32'h0, shd[idx][63:32]} : {32'h0, shd[idx][31:0]});
         if (f5 == 5'b00011) begin
            if (res_v && res_a == a) begin
               exp_w = 1;
               nv = dw ? b : {32'h0, b[31:0]};
            end else begin
               exp_rd = 64'd1;
            end
            res_v = 1'b0;
         end else begin
            exp_r  = 1;
            exp_rd = dw ? old : {{32{old[31]}}, old[31:0]};
            if (f5 == 5'b00010) begin
               res_v = 1'b1;
               res_a = a;
            end else begin
               exp_w = 1;
               nv = ref_new(f5, dw, old, b);
            end
         end
         if (exp_w == 1) begin
            if (dw) shd[idx] = nv;
            else if (a[2]) shd[idx][63:32] = nv[31:0];
            else shd[idx][31:0] = nv[31:0];
         end
      end
      r0 = rd_cnt; w0 = wr_cnt;
      @(negedge clk);
      chk(req_ready == 1'b1, "R9", "ready before request", 64'(req_ready), 64'd1);
      req_valid = 1'b1; req_funct5 = f5; req_funct3 = f3; req_rs2_field = rs2f;
      req_addr = a; req_rs2_val = b;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R9", "busy after accept", 64'(req_ready), 64'd0);
      n = 0;
      while (!rsp_done && n < 40) begin
         @(negedge clk);
         n++;
      end
      chk(rsp_done == 1'b1, tag, "completion", 64'(rsp_done), 64'd1);
      chk(rsp_rd_val == exp_rd, tag, "rd value", rsp_rd_val, exp_rd);
      chk(rsp_illegal == ill, "R4", "illegal flag", 64'(rsp_illegal), 64'(ill));
      chk(rsp_misaligned == mis, "R8", "misaligned flag", 64'(rsp_misaligned), 64'(mis));
      chk(rd_cnt - r0 == exp_r, tag, "read count", 64'(rd_cnt - r0), 64'(exp_r));
      chk(wr_cnt - w0 == exp_w, tag, "write count", 64'(wr_cnt - w0), 64'(exp_w));
      mem_ok = 1'b1;
      for (int k = 0; k < 16; k++) if (mem[k] !== shd[k]) mem_ok = 1'b0;
      chk(mem_ok, tag, "memory image word", mem[idx], shd[idx]);
      @(negedge clk);
      chk(!rsp_done && req_ready, "R9", "done pulse ends", {62'd0, rsp_done, req_ready}, 64'd1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      logic [4:0] f5_list [11];
      int dummy;
      dummy = int'($urandom(32'd2024));
      f5_list = '{5'b00001, 5'b00000, 5'b00100, 5'b01100, 5'b01000,
                  5'b10000, 5'b10100, 5'b11000, 5'b11100, 5'b00010, 5'b00011};
      for (int k = 0; k < 16; k++) shd[k] = init_word(k);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      chk(req_ready == 1'b1, "R11", "req_ready after reset", 64'(req_ready), 64'd1);
      chk(!mem_rd_req && !mem_wr_req && !rsp_done, "R11", "strobes after reset",
          {61'd0, mem_rd_req, mem_wr_req, rsp_done}, 64'd0);
      run_op(5'b00011, 3'b011, 5'd0, 16'h0010, 64'h1111, "R11");

      // R1 / R2 / R3: each operation, both sizes, signed corner values
      for (int j = 0; j < 9; j++) begin
         run_op(f5_list[j], 3'b011, 5'd1, 16'h0018, 64'h8000_0000_0000_0003 + 64'(j), "R1");
         run_op(f5_list[j], 3'b010, 5'd2, 16'h0024, 64'hFFFF_FFFF_8000_0005 - 64'(j), "R2");
         run_op(f5_list[j], 3'b010, 5'd3, 16'h0020, 64'h0000_0000_7FFF_FFF0 + 64'(j), "R3");
      end

      // R5 / R6 / R7: reservation pairings
      run_op(5'b00010, 3'b011, 5'd0, 16'h0030, 64'h0, "R5");
      run_op(5'b00011, 3'b011, 5'd4, 16'h0030, 64'hDEAD_BEEF_0123_4567, "R6");
      run_op(5'b00011, 3'b011, 5'd4, 16'h0030, 64'h5555, "R7");
      run_op(5'b00010, 3'b010, 5'd0, 16'h003C, 64'h0, "R5");
      run_op(5'b00011, 3'b010, 5'd4, 16'h0038, 64'h7777, "R6");
      run_op(5'b00011, 3'b010, 5'd4, 16'h003C, 64'h7777, "R7");
      run_op(5'b00010, 3'b010, 5'd3, 16'h0044, 64'h0, "R5");

      // R4: illegal encodings
      run_op(5'b00000, 3'b000, 5'd0, 16'h0040, 64'h9, "R4");
      run_op(5'b00101, 3'b011, 5'd0, 16'h0040, 64'h9, "R4");
      run_op(5'b00001, 3'b110, 5'd0, 16'h0040, 64'h9, "R4");

      // R8: misaligned, reservation survives a misaligned store-conditional
      run_op(5'b00000, 3'b011, 5'd0, 16'h0014, 64'h1, "R8");
      run_op(5'b00010, 3'b011, 5'd0, 16'h0048, 64'h0, "R5");
      run_op(5'b00011, 3'b011, 5'd0, 16'h0049, 64'h2, "R8");
      run_op(5'b00011, 3'b011, 5'd0, 16'h0048, 64'hCAFE, "R8");

      // R10: random stream under random read latency
      for (int j = 0; j < 400; j++) begin
         logic [4:0]  f5;
         logic [2:0]  f3;
         logic [15:0] a;
         logic [63:0] b;
         f5 = ($urandom % 16 == 0) ? 5'($urandom) : f5_list[$urandom % 11];
         f3 = ($urandom % 16 == 0) ? 3'($urandom) : (($urandom % 2 == 0) ? 3'b010 : 3'b011);
         a  = {9'd0, 4'($urandom), 3'd0};
         if ($urandom % 2 == 0) a[2] = 1'b1;
         if ($urandom % 8 == 0) a[1:0] = 2'($urandom);
         b  = {$urandom, $urandom};
         run_op(f5, f3, ($urandom % 8 == 0) ? 5'($urandom) : 5'd0, a, b, "R10");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule